// File: doc/BRIEF.md
# Hardware-Initiated Link Low-Power Entry Controller

This block decides, without software involvement, when each port of a small packet switch may move its transmit side into the standby (L0s) or deep-idle (L1) link states. The switch has one upstream port (index 0) and `NUM_DN` downstream ports (indices 1 to `NUM_DN`). Each port runs its own state machine with four states:
- ACTIVE (L0).
- STANDBY (L0s).
- L1_ASK, the L1 handshake with the link partner.
- L1_SLEEP (L1).

An idle timer per port gates the move out of ACTIVE. The timer restarts whenever the port has something it can send or a fresh TLP shows up.

A port's standby entry depends on the receive side of the other ports. The upstream port waits until every qualifying downstream receiver is in L0s. A downstream port waits for the upstream receiver. A downstream port counts as qualifying when it is neither in D3 nor link-down.

Only the upstream port asks for L1, and only once every qualifying downstream link is already in L1. The partner may grant the request, refuse it, or let it time out; a refusal or a timeout drops the port back to standby. The transitions are:
- ACTIVE to L1_ASK, with priority over ACTIVE to STANDBY.
- STANDBY to ACTIVE on exit.
- STANDBY to L1_ASK.
- L1_ASK to L1_SLEEP on a grant.
- L1_ASK to STANDBY on a refusal or a timeout.
- L1_SLEEP to ACTIVE on exit.

Top module: `aspm_entry_ctrl`

## Requirements
- R1: `aspm_ctl` bit 0 enables L0s entry and bit 1 enables L1 requests. With a bit clear, hardware starts no such entry.
- R2: A port's transmit side is idle when it has no DLLP pending, and either no TLP pending or no flow-control credit for it. A TLP without credit does not block entry and does not cause an exit.
- R3: After a busy cycle, entry from ACTIVE takes effect `idle_thresh`+1 clock edges after the first idle edge. A rising `tlp_pend` bit restarts that count even while the port stays idle.
- R4: The upstream port enters L0s only when every downstream port with its `dn_d3` and `dn_down` bits clear has its `rx_l0s` bit set. If no downstream port qualifies, the condition holds.
- R5: A downstream port enters L0s only while `rx_l0s[0]` (the upstream receiver) is set, and only when its own port is idle.
- R6: In STANDBY or L1_SLEEP, a port that is not idle raises its `exit_req` bit in the same cycle and is in ACTIVE after the next edge.
- R7: Only the upstream port raises `l1_req`. It does so from ACTIVE or STANDBY, with L1 enabled and the idle count met, when every qualifying downstream port has `dn_l1` set. This takes priority over L0s entry. `l1_req` stays high until the partner answers.
- R8: `l1_ack` during a request moves the upstream port to L1 after the next edge.
- R9: `l1_nak` during a request (without `l1_ack`) moves the upstream port to L0s after the next edge. No new L1 request follows until the port has returned to ACTIVE.
- R10: A request that gets no answer ends at the (`l1_timeout`+1)th edge after it began, and the port falls back to L0s.
- R11: `pwr_state[2p+1:2p]` reports port p as 0 for L0, 1 for L0s, 2 for L1 and 3 for an L1 handshake in progress. `l0s_req[p]` is high exactly while port p is in L0s.
- R12: After reset, every port is in L0 and no request or exit output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aspm_ctl | input | 2 | Bit 0 enables L0s, bit 1 enables L1 |
| idle_thresh | input | CNT_W | Idle cycles required before entry |
| l1_timeout | input | TMO_W | Wait limit for an L1 answer |
| rx_l0s | input | NPORT | Receive lanes of port p are in L0s |
| dn_l1 | input | NUM_DN | Downstream link i (port i+1) is in L1 |
| dn_d3 | input | NUM_DN | Downstream port i is in D3 |
| dn_down | input | NUM_DN | Downstream link i is down |
| tlp_pend | input | NPORT | TLP waiting on port p |
| fc_avail | input | NPORT | Flow-control credit present on port p |
| dllp_pend | input | NPORT | DLLP waiting on port p |
| l1_ack | input | 1 | Partner grants the L1 request |
| l1_nak | input | 1 | Partner refuses the L1 request |
| l0s_req | output | NPORT | Port p transmit side held in L0s |
| exit_req | output | NPORT | Port p must return to L0 |
| l1_req | output | 1 | Upstream L1 request |
| pwr_state | output | 2*NPORT | Per-port link power code |

## Verification
`exit_req` is combinational and is due in the same cycle as the stimulus that makes a port busy. Every state change and every `l0s_req`, `l1_req` and `pwr_state` change is due one edge after the deciding inputs. Idle-gated entries are due `idle_thresh`+1 edges after the first idle edge, and a timeout falls back `l1_timeout`+1 edges after the request began.

The driver computes the target cycle for each expected value from these counts and queues it. The monitor compares the outputs at the falling edge of exactly that cycle, so each check lands on the first cycle of a new value or the last cycle of an old one.

// File: rtl/aspm_pkg.sv
package aspm_pkg;

    // Link power code reported per port
    typedef enum logic [1:0] {
        PS_L0   = 2'd0,
        PS_L0S  = 2'd1,
        PS_L1   = 2'd2,
        PS_L1HS = 2'd3
    } pwr_code_t;

    // Per-port transmit-side state
    typedef enum logic [1:0] {
        S_ACTIVE,
        S_STANDBY,
        S_L1_ASK,
        S_L1_SLEEP
    } port_st_t;

endpackage

// File: rtl/aspm_idle_timer.sv
module aspm_idle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_idle,
    input  logic             tlp_pend,
    input  logic [CNT_W-1:0] thresh,
    output logic             ready
);
    logic [CNT_W-1:0] cnt;
    logic             tlp_q;
    logic             restart;

    // Busy, or a fresh TLP appeared: start counting again
    assign restart = !tx_idle || (tlp_pend && !tlp_q);
    assign ready   = !restart && (cnt >= thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            tlp_q <= 1'b0;
        end else begin
            tlp_q <= tlp_pend;
            if (restart)
                cnt <= '0;
            else if (cnt < thresh)
                cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/aspm_port_fsm.sv
module aspm_port_fsm
    import aspm_pkg::*;
#(
    parameter int HAS_L1 = 0,
    parameter int TMO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_l0s,
    input  logic             en_l1,
    input  logic             tx_idle,
    input  logic             ready,
    input  logic             rx_ok,
    input  logic             all_l1,
    input  logic             ack,
    input  logic             nak,
    input  logic [TMO_W-1:0] tmo_lim,
    output logic             l0s_req,
    output logic             l1_req,
    output logic             exit_req,
    output pwr_code_t        pcode
);
    localparam bit L1_CAP = (HAS_L1 != 0);

    port_st_t         state, nxt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             backoff;
    logic             timeout;
    logic             l1_go;
    logic             l0s_go;

    assign timeout = (tmo_cnt == tmo_lim);
    assign l1_go   = L1_CAP && en_l1 && all_l1 && ready && !backoff;
    assign l0s_go  = en_l0s && rx_ok && ready;

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_ACTIVE: begin
                if (l1_go)
                    nxt = S_L1_ASK;
                else if (l0s_go)
                    nxt = S_STANDBY;
            end
            S_STANDBY: begin
                if (!tx_idle)
                    nxt = S_ACTIVE;
                else if (l1_go)
                    nxt = S_L1_ASK;
            end
            S_L1_ASK: begin
                if (ack)
                    nxt = S_L1_SLEEP;
                else if (nak || timeout)
                    nxt = S_STANDBY;
            end
            S_L1_SLEEP: begin
                if (!tx_idle)
                    nxt = S_ACTIVE;
            end
            default: nxt = S_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_ACTIVE;
        else
            state <= nxt;
    end

    // Handshake timer and retry block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_cnt <= '0;
            backoff <= 1'b0;
        end else begin
            if (state != S_L1_ASK)
                tmo_cnt <= '0;
            else
                tmo_cnt <= tmo_cnt + TMO_W'(1);
            if (state == S_L1_ASK && !ack && (nak || timeout))
                backoff <= 1'b1;
            else if (state == S_ACTIVE)
                backoff <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        l0s_req  = 1'b0;
        l1_req   = 1'b0;
        exit_req = 1'b0;
        pcode    = PS_L0;
        unique case (state)
            S_ACTIVE: pcode = PS_L0;
            S_STANDBY: begin
                l0s_req  = 1'b1;
                exit_req = !tx_idle;
                pcode    = PS_L0S;
            end
            S_L1_ASK: begin
                l1_req = 1'b1;
                pcode  = PS_L1HS;
            end
            S_L1_SLEEP: begin
                exit_req = !tx_idle;
                pcode    = PS_L1;
            end
            default: pcode = PS_L0;
        endcase
    end
endmodule

// File: rtl/aspm_entry_ctrl.sv
module aspm_entry_ctrl
    import aspm_pkg::*;
#(
    parameter int NUM_DN = 3,
    parameter int CNT_W  = 8,
    parameter int TMO_W  = 8,
    localparam int NPORT = NUM_DN + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         aspm_ctl,
    input  logic [CNT_W-1:0]   idle_thresh,
    input  logic [TMO_W-1:0]   l1_timeout,
    input  logic [NPORT-1:0]   rx_l0s,
    input  logic [NUM_DN-1:0]  dn_l1,
    input  logic [NUM_DN-1:0]  dn_d3,
    input  logic [NUM_DN-1:0]  dn_down,
    input  logic [NPORT-1:0]   tlp_pend,
    input  logic [NPORT-1:0]   fc_avail,
    input  logic [NPORT-1:0]   dllp_pend,
    input  logic               l1_ack,
    input  logic               l1_nak,
    output logic [NPORT-1:0]   l0s_req,
    output logic [NPORT-1:0]   exit_req,
    output logic               l1_req,
    output logic [2*NPORT-1:0] pwr_state
);
    logic [NUM_DN-1:0] qual;
    logic              up_rx_ok;
    logic              dn_all_l1;
    logic [NPORT-1:0]  tx_idle;
    logic [NPORT-1:0]  ready;
    logic [NPORT-1:0]  l1_req_v;

    // Ports in D3 or link-down drop out of the all-ports checks
    assign qual      = ~(dn_d3 | dn_down);
    assign up_rx_ok  = &(rx_l0s[NPORT-1:1] | ~qual);
    assign dn_all_l1 = &(dn_l1 | ~qual);
    assign l1_req    = |l1_req_v;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pwr_code_t pcode;
        logic      rx_ok;

        assign tx_idle[p] = !dllp_pend[p] && (!tlp_pend[p] || !fc_avail[p]);
        assign pwr_state[2*p +: 2] = pcode;

        if (p == 0) begin : g_up
            assign rx_ok = up_rx_ok;
        end else begin : g_dn
            assign rx_ok = rx_l0s[0];
        end

        aspm_idle_timer #(.CNT_W(CNT_W)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_idle  (tx_idle[p]),
            .tlp_pend (tlp_pend[p]),
            .thresh   (idle_thresh),
            .ready    (ready[p])
        );

        aspm_port_fsm #(.HAS_L1(p == 0 ? 1 : 0), .TMO_W(TMO_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_l0s   (aspm_ctl[0]),
            .en_l1    (aspm_ctl[1]),
            .tx_idle  (tx_idle[p]),
            .ready    (ready[p]),
            .rx_ok    (rx_ok),
            .all_l1   (dn_all_l1),
            .ack      (p == 0 ? l1_ack : 1'b0),
            .nak      (p == 0 ? l1_nak : 1'b0),
            .tmo_lim  (l1_timeout),
            .l0s_req  (l0s_req[p]),
            .l1_req   (l1_req_v[p]),
            .exit_req (exit_req[p]),
            .pcode    (pcode)
        );
    end
endmodule

// File: rtl/aspm_entry_chk.sv
module aspm_entry_chk #(
    parameter int NUM_DN = 3,
    localparam int NPORT = NUM_DN + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         aspm_ctl,
    input logic [NPORT-1:0]   rx_l0s,
    input logic               l1_ack,
    input logic               l1_nak,
    input logic [NPORT-1:0]   l0s_req,
    input logic [NPORT-1:0]   exit_req,
    input logic               l1_req,
    input logic [2*NPORT-1:0] pwr_state
);
    // R1: a new standby entry not coming from a refused L1 needs the L0s enable
    a_r1_l0s_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (((l0s_req & ~$past(l0s_req)) != '0) && !$past(l1_req)) |-> $past(aspm_ctl[0]));

    // R5: downstream standby entry follows the upstream receiver
    a_r5_dn_follows_up_rx: assert property (@(posedge clk) disable iff (!rst_n)
        ((l0s_req[NPORT-1:1] & ~$past(l0s_req[NPORT-1:1])) != '0) |-> $past(rx_l0s[0]));

    // R6: an exit request removes the port from standby
    a_r6_exit_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_req != '0) |=> ((l0s_req & $past(exit_req)) == '0));

    // R7: a request only starts with the L1 enable set
    a_r7_l1_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l1_req) |-> $past(aspm_ctl[1]));

    // R8: a grant lands in L1
    a_r8_grant_to_l1: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req && l1_ack) |=> (pwr_state[1:0] == 2'd2));

    // R9: a refusal falls back to standby
    a_r9_refuse_to_l0s: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req && l1_nak && !l1_ack) |=> (pwr_state[1:0] == 2'd1 && !l1_req));
endmodule

bind aspm_entry_ctrl aspm_entry_chk #(.NUM_DN(NUM_DN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .aspm_ctl  (aspm_ctl),
    .rx_l0s    (rx_l0s),
    .l1_ack    (l1_ack),
    .l1_nak    (l1_nak),
    .l0s_req   (l0s_req),
    .exit_req  (exit_req),
    .l1_req    (l1_req),
    .pwr_state (pwr_state)
);

// File: tb/test_aspm_entry_ctrl.sv
`timescale 1ns/1ps
module test_aspm_entry_ctrl;
    localparam int NUM_DN = 3;
    localparam int NPORT  = NUM_DN + 1;
    localparam int CNT_W  = 8;
    localparam int TMO_W  = 8;
    localparam int THR    = 4;
    localparam int TMO    = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         aspm_ctl = '0;
    logic [CNT_W-1:0]   idle_thresh = CNT_W'(THR);
    logic [TMO_W-1:0]   l1_timeout = TMO_W'(TMO);
    logic [NPORT-1:0]   rx_l0s = '0;
    logic [NUM_DN-1:0]  dn_l1 = '0;
    logic [NUM_DN-1:0]  dn_d3 = '0;
    logic [NUM_DN-1:0]  dn_down = '0;
    logic [NPORT-1:0]   tlp_pend = '1;
    logic [NPORT-1:0]   fc_avail = '1;
    logic [NPORT-1:0]   dllp_pend = '0;
    logic               l1_ack = 1'b0;
    logic               l1_nak = 1'b0;
    logic [NPORT-1:0]   l0s_req;
    logic [NPORT-1:0]   exit_req;
    logic               l1_req;
    logic [2*NPORT-1:0] pwr_state;

    aspm_entry_ctrl #(.NUM_DN(NUM_DN), .CNT_W(CNT_W), .TMO_W(TMO_W)) i_aspm_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .aspm_ctl(aspm_ctl), .idle_thresh(idle_thresh),
        .l1_timeout(l1_timeout), .rx_l0s(rx_l0s), .dn_l1(dn_l1), .dn_d3(dn_d3),
        .dn_down(dn_down), .tlp_pend(tlp_pend), .fc_avail(fc_avail),
        .dllp_pend(dllp_pend), .l1_ack(l1_ack), .l1_nak(l1_nak),
        .l0s_req(l0s_req), .exit_req(exit_req), .l1_req(l1_req), .pwr_state(pwr_state)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc = cyc + 1;

    // sel: 0 l0s_req, 1 exit_req, 2 l1_req, 3 upstream code, 4 all codes
    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return 32'(l0s_req);
            1: return 32'(exit_req);
            2: return 32'(l1_req);
            3: return 32'(pwr_state[1:0]);
            default: return 32'(pwr_state);
        endcase
    endfunction

    // Driver side: queue an expected value due dly edges from now
    task automatic expect_at(int dly, int sel, logic [31:0] v, string tag);
        exp_t e;
        int   pos;
        e.cyc = cyc + dly; e.sel = sel; e.exp = v; e.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc > e.cyc) begin pos = i; break; end
        end
        q.insert(pos, e);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            logic [31:0] act;
            e = q.pop_front();
            act = observe(e.sel);
            n_chk++;
            if (act !== e.exp) begin
                n_bad++;
                $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                         e.tag, e.sel, cyc, act, e.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            if (q.size() != 0) begin
                n_bad += q.size();
                $display("FAIL unchecked items=%0d actual=pending expected=none", q.size());
            end
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #20000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12: reset state
        expect_at(0, 0, 0, "R12");
        expect_at(0, 2, 0, "R12");
        expect_at(0, 4, 0, "R12");
        expect_at(0, 1, 0, "R12");

        // R1: idle everywhere but enables clear
        tlp_pend = '0; rx_l0s = '1;
        tick(10);
        expect_at(0, 0, 0, "R1");
        aspm_ctl = 2'b01;
        expect_at(1, 0, 4'hF, "R1");
        expect_at(1, 4, 32'h55, "R11");
        tick(1);

        // R6: sendable TLP on port 2 forces exit; R3 re-entry timing
        tlp_pend[2] = 1'b1;
        expect_at(0, 1, 4'b0100, "R6");
        expect_at(1, 0, 4'b1011, "R6");
        expect_at(1, 1, 0, "R6");
        tick(1);
        tlp_pend[2] = 1'b0;
        expect_at(THR, 0, 4'b1011, "R3");
        expect_at(THR + 1, 0, 4'hF, "R3");
        tick(THR + 1);

        // R2: DLLP forces exit on port 3; R3: new TLP without credit restarts count
        dllp_pend[3] = 1'b1;
        expect_at(0, 1, 4'b1000, "R2");
        tick(1);
        dllp_pend[3] = 1'b0;
        tick(2);
        tlp_pend[3] = 1'b1; fc_avail[3] = 1'b0;
        expect_at(0, 1, 0, "R2");
        expect_at(3, 0, 4'b0111, "R3");
        expect_at(5, 0, 4'b0111, "R3");
        expect_at(6, 0, 4'hF, "R3");
        tick(6);
        // R2: credit arrives, TLP becomes sendable
        fc_avail[3] = 1'b1;
        expect_at(0, 1, 4'b1000, "R2");
        expect_at(1, 0, 4'b0111, "R2");
        tick(1);
        tlp_pend[3] = 1'b0;
        tick(THR + 1);

        // R4/R5: receivers block entry
        tlp_pend = '1; rx_l0s = 4'b1010;
        expect_at(1, 0, 0, "R6");
        tick(1);
        tlp_pend = '0;
        expect_at(THR + 1, 0, 0, "R4,R5");
        tick(THR + 1);
        rx_l0s[0] = 1'b1;
        expect_at(1, 0, 4'b1110, "R5");
        tick(1);
        dn_down[1] = 1'b1;   // port 2 masked by link-down
        expect_at(1, 0, 4'hF, "R4");
        tick(1);

        // R7/R8: L1 request and grant
        dn_l1 = 3'b101; aspm_ctl = 2'b11;
        expect_at(0, 2, 0, "R7");
        expect_at(1, 2, 1, "R7");
        expect_at(1, 3, 3, "R11");
        tick(1);
        l1_ack = 1'b1;
        expect_at(1, 3, 2, "R8");
        expect_at(1, 2, 0, "R8");
        expect_at(1, 0, 4'b1110, "R8");
        tick(1);
        l1_ack = 1'b0;

        // R6: exit from L1, then R7 request from L0 and R9 refusal
        dllp_pend[0] = 1'b1;
        expect_at(0, 1, 1, "R6");
        expect_at(1, 3, 0, "R6");
        tick(1);
        dllp_pend[0] = 1'b0;
        expect_at(THR, 2, 0, "R3");
        expect_at(THR + 1, 2, 1, "R7");
        tick(THR + 1);
        l1_nak = 1'b1;
        expect_at(1, 3, 1, "R9");
        expect_at(1, 2, 0, "R9");
        tick(1);
        l1_nak = 1'b0;
        expect_at(5, 2, 0, "R9");
        expect_at(5, 3, 1, "R9");
        tick(5);

        // R10: unanswered request times out
        dllp_pend[0] = 1'b1;
        tick(1);
        dllp_pend[0] = 1'b0;
        expect_at(THR + 1, 2, 1, "R10");
        expect_at(THR + 1 + TMO, 2, 1, "R10");
        expect_at(THR + 2 + TMO, 2, 0, "R10");
        expect_at(THR + 2 + TMO, 3, 1, "R10");
        tick(THR + 2 + TMO);

        // R7: a qualifying downstream link not in L1 blocks the request
        dllp_pend[0] = 1'b1;
        tick(1);
        dllp_pend[0] = 1'b0; dn_l1[0] = 1'b0;
        expect_at(THR + 1, 2, 0, "R7");
        expect_at(THR + 1, 3, 1, "R7");
        tick(THR + 1);
        dn_d3[0] = 1'b1;     // masking by D3
        expect_at(1, 2, 1, "R4");
        tick(1);
        l1_ack = 1'b1;
        tick(1);
        l1_ack = 1'b0;

        // R4: no qualifying downstream port counts as satisfied
        dllp_pend[0] = 1'b1;
        tick(1);
        dllp_pend[0] = 1'b0; dn_l1 = '0; dn_d3 = '1;
        expect_at(THR + 1, 2, 1, "R4");
        tick(THR + 1);
        l1_ack = 1'b1;
        expect_at(1, 3, 2, "R8");
        tick(1);
        l1_ack = 1'b0;

        tick(3);
        finish_run();
    end
endmodule